// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sequences the two gate commands of one synchronous buck phase. A three-level PWM command selects the high-side switch, the low-side switch, or a diode-emulation cycle. A three-level enable either lets the phase run or parks both gates low. A supply-good flag from an undervoltage comparator overrides everything else.

Dead time is adaptive. Before a gate turns on, the opposite gate must report that it has fallen below its threshold. A programmable delay in clock cycles then has to elapse. In diode emulation, the low side first turns on through the same path. It then stays on for a programmable blanking interval, and after that it turns off at the first zero-cross indication. A new PWM level at any point restarts the sequence toward the new target.

The inputs come from digital comparators and a controller. The gate outputs go to the level shifters and drivers.

Top module: `buck_gate_seq`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never high in the same cycle.
- R2: While `supply_ok_i` is low, both gate outputs are low from the next cycle on. `en_stat_o` is a one-cycle registered copy of `supply_ok_i`, so it is low whenever the supply was not good in the previous cycle.
- R3: Level inputs are coded 00 = low, 01 = mid, 10 = high. When the enable is not high (00 or 01), both gate outputs are low from the next cycle on.
- R4: For PWM high (10), the low-side output drops in the next cycle. The high-side output rises one cycle after the edge at which `ls_below_i` has been high for `hs_dly_i`+1 consecutive samples. While the flag is low, the high side stays off.
- R5: For PWM low (00), the high-side output drops in the next cycle. The low-side output rises one cycle after the edge at which `hs_below_i` has been high for `ls_dly_i`+1 consecutive samples.
- R6: For PWM mid (01), the high side goes low and the low side turns on through the R5 path. It then stays high for at least `blank_dly_i` cycles (at least one), whatever `zc_det_i` does. After that it stays high until a zero-cross is seen.
- R7: After blanking, a high `zc_det_i` drops the low-side output in the next cycle. It stays low for as long as the PWM level stays mid.
- R8: A change of PWM level during any wait, on-state, blanking or diode phase restarts the sequence at once toward the new level. The dead-time counters restart from zero.
- R9: When the phase becomes active again (enable high and supply good), both outputs start from low. The gate that the current PWM level calls for is then turned on through the R4 or R5 path.
- R10: Code 11 on either level input behaves exactly as mid (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| en_lvl_i | input | 2 | Three-level enable code |
| pwm_lvl_i | input | 2 | Three-level PWM code |
| hs_below_i | input | 1 | High-side gate below threshold |
| ls_below_i | input | 1 | Low-side gate below threshold |
| zc_det_i | input | 1 | Switch-node zero-cross detected |
| hs_dly_i | input | CNT_W | High-side turn-on delay, cycles |
| ls_dly_i | input | CNT_W | Low-side turn-on delay, cycles |
| blank_dly_i | input | CNT_W | Zero-cross blanking interval, cycles |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| en_stat_o | output | 1 | Enable status, low under undervoltage |

## Verification
The bench holds a below-threshold flag low for several cycles to test the adaptive wait. A design that counted the delay from the PWM edge alone would turn a gate on while the opposite gate was still conducting. It holds the zero-cross input high throughout blanking, which catches a low side released early. It also keeps the PWM mid after the zero-cross to catch a low side that turns back on. It reverses the PWM level inside a dead-time wait and brings the enable back high while the PWM is high, which exposes a sequence that resumes from stale state or skips the non-overlap path. Random runs with zero delays and a zero blanking length cover the counter boundaries.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [1:0] {LVL_LOW, LVL_MID, LVL_HIGH} lvl_e;
  typedef enum logic [2:0] {
    ST_OFF, ST_HS_WAIT, ST_HS_ON, ST_LS_WAIT, ST_LS_ON, ST_BLANK, ST_DIODE
  } seq_st_e;
endpackage

// File: rtl/lvl_decode.sv
module lvl_decode
  import buck_seq_pkg::*;
(
  input  logic [1:0] code_i,
  output lvl_e       lvl_o
);
  always_comb begin
    unique case (code_i)
      2'b00:   lvl_o = LVL_LOW;
      2'b10:   lvl_o = LVL_HIGH;
      default: lvl_o = LVL_MID; // 01 and 11
    endcase
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_one_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (load_one_i)                  cnt_o <= CNT_ONE;
    else if (clr_i)                       cnt_o <= '0;
    else if (step_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_ONE;
  end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import buck_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  lvl_e             pwm_i,
  input  logic             hs_below_i,
  input  logic             ls_below_i,
  input  logic             zc_det_i,
  input  logic [CNT_W-1:0] hs_dly_i,
  input  logic [CNT_W-1:0] ls_dly_i,
  input  logic [CNT_W-1:0] blank_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             load_one_o,
  output logic             step_o,
  output logic             hs_o,
  output logic             ls_o
);
  seq_st_e st_q, st_d;
  lvl_e    tgt_q, tgt_d;

  always_comb begin
    st_d       = st_q;
    tgt_d      = tgt_q;
    clr_o      = 1'b0;
    load_one_o = 1'b0;
    step_o     = 1'b0;
    if (!active_i) begin
      st_d  = ST_OFF;
      clr_o = 1'b1;
    end else if (st_q == ST_OFF || pwm_i != tgt_q) begin
      // restart toward the commanded level, both gates off first
      tgt_d = pwm_i;
      st_d  = (pwm_i == LVL_HIGH) ? ST_HS_WAIT : ST_LS_WAIT;
      clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_HS_WAIT: begin
          if (!ls_below_i) clr_o = 1'b1;
          else if (cnt_i == hs_dly_i) begin
            st_d  = ST_HS_ON;
            clr_o = 1'b1;
          end else step_o = 1'b1;
        end
        ST_LS_WAIT: begin
          if (!hs_below_i) clr_o = 1'b1;
          else if (cnt_i == ls_dly_i) begin
            if (tgt_q == LVL_MID) begin
              st_d       = ST_BLANK;
              load_one_o = 1'b1;
            end else begin
              st_d  = ST_LS_ON;
              clr_o = 1'b1;
            end
          end else step_o = 1'b1;
        end
        ST_BLANK: begin
          if (cnt_i >= blank_i && zc_det_i) begin
            st_d  = ST_DIODE;
            clr_o = 1'b1;
          end else step_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      tgt_q <= LVL_LOW;
      hs_o  <= 1'b0;
      ls_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      hs_o  <= (st_d == ST_HS_ON);
      ls_o  <= (st_d == ST_LS_ON) || (st_d == ST_BLANK);
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  a_r3_inactive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!hs_o && !ls_o));
  a_r4_hs_after_ls_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(ls_below_i));
  a_r5_ls_after_hs_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> $past(hs_below_i));
  a_r6_blank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLANK && cnt_i < blank_i && active_i && pwm_i == tgt_q) |=> ls_o);
  a_r7_diode_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIODE && active_i && pwm_i == tgt_q) |=> !ls_o);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic [1:0]       en_lvl_i,
  input  logic [1:0]       pwm_lvl_i,
  input  logic             hs_below_i,
  input  logic             ls_below_i,
  input  logic             zc_det_i,
  input  logic [CNT_W-1:0] hs_dly_i,
  input  logic [CNT_W-1:0] ls_dly_i,
  input  logic [CNT_W-1:0] blank_dly_i,
  output logic             hs_gate_o,
  output logic             ls_gate_o,
  output logic             en_stat_o
);
  lvl_e             en_lvl, pwm_lvl;
  logic             active;
  logic             clr, load_one, step;
  logic [CNT_W-1:0] cnt;

  lvl_decode u_en_dec  (.code_i(en_lvl_i),  .lvl_o(en_lvl));
  lvl_decode u_pwm_dec (.code_i(pwm_lvl_i), .lvl_o(pwm_lvl));

  assign active = supply_ok_i && (en_lvl == LVL_HIGH);

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .clr_i(clr), .load_one_i(load_one), .step_i(step), .cnt_o(cnt)
  );

  gate_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .active_i(active), .pwm_i(pwm_lvl),
    .hs_below_i, .ls_below_i, .zc_det_i,
    .hs_dly_i, .ls_dly_i, .blank_i(blank_dly_i),
    .cnt_i(cnt), .clr_o(clr), .load_one_o(load_one), .step_o(step),
    .hs_o(hs_gate_o), .ls_o(ls_gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_stat_o <= 1'b0;
    else         en_stat_o <= supply_ok_i;
  end

  a_r2_uvlo_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!hs_gate_o && !ls_gate_o && !en_stat_o));
  a_r10_en_code11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_lvl_i == 2'b11) |=> (!hs_gate_o && !ls_gate_o));
endmodule

// File: tb/buck_gate_seq_tb_top.sv
`timescale 1ns/1ps
module buck_gate_seq_tb_top;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic sup = 0, hsb = 0, lsb = 0, zc = 0;
  logic [1:0] en = 2'b00, pwm = 2'b00;
  logic [CW-1:0] dhs = 3, dls = 2, blk = 4;
  logic hs, ls, stat;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  always #2 clk = ~clk;

  buck_gate_seq #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .en_lvl_i(en),
    .pwm_lvl_i(pwm), .hs_below_i(hsb), .ls_below_i(lsb), .zc_det_i(zc),
    .hs_dly_i(dhs), .ls_dly_i(dls), .blank_dly_i(blk),
    .hs_gate_o(hs), .ls_gate_o(ls), .en_stat_o(stat)
  );

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int dec(logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  // reference model: 0 off,1 hs wait,2 hs on,3 ls wait,4 ls on,5 blank,6 diode
  int m_st = 0, m_tgt = 0, m_cnt = 0;
  logic m_stat = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tgt = 0; m_cnt = 0; m_stat = 0;
    end else begin
      int p;
      p = dec(pwm);
      m_stat = sup;
      if (!(sup && dec(en) == 2)) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0 || p != m_tgt) begin
        m_tgt = p; m_st = (p == 2) ? 1 : 3; m_cnt = 0;
      end else begin
        case (m_st)
          1: if (!lsb) m_cnt = 0;
             else if (m_cnt == int'(dhs)) begin m_st = 2; m_cnt = 0; end
             else m_cnt++;
          3: if (!hsb) m_cnt = 0;
             else if (m_cnt == int'(dls)) begin
               if (m_tgt == 1) begin m_st = 5; m_cnt = 1; end
               else begin m_st = 4; m_cnt = 0; end
             end else m_cnt++;
          5: if (m_cnt >= int'(blk) && zc) begin m_st = 6; m_cnt = 0; end
             else if (m_cnt < CMAX) m_cnt++;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R1 overlap", hs && ls, 1'b0);
      check("R4 model hs", hs, m_st == 2);
      check("R5 model ls", ls, m_st == 4 || m_st == 5);
      check("R2 model stat", stat, m_stat);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R2 reset hs", hs, 0); check("R2 reset ls", ls, 0); check("R2 reset stat", stat, 0);
    rst_n = 1; cmp_on = 1;
    // R2: supply low blocks everything
    en = 2'b10; pwm = 2'b10; lsb = 1; hsb = 1;
    tick(8);
    check("R2 uvlo hs", hs, 0); check("R2 uvlo stat", stat, 0);
    sup = 1;
    tick(1); check("R2 stat follows", stat, 1); check("R9 start low", hs, 0);
    tick(3); check("R4 delay", hs, 0);
    tick(1); check("R4 hs on", hs, 1);
    // R5 path
    pwm = 2'b00; hsb = 0; lsb = 0;
    tick(1); check("R5 hs drops", hs, 0); check("R5 ls off", ls, 0);
    tick(4); check("R5 waits flag", ls, 0);
    hsb = 1;
    tick(2); check("R5 delay", ls, 0);
    tick(1); check("R5 ls on", ls, 1);
    // R4 path
    pwm = 2'b10; lsb = 0;
    tick(1); check("R4 ls drops", ls, 0); check("R4 hs off", hs, 0);
    tick(4); check("R4 waits flag", hs, 0);
    lsb = 1;
    tick(3); check("R4 delay2", hs, 0);
    tick(1); check("R4 hs on2", hs, 1);
    // R8 restart inside a wait
    pwm = 2'b00; hsb = 0;
    tick(1); check("R8 hs drop", hs, 0);
    pwm = 2'b10;
    tick(4); check("R8 restarted wait", hs, 0); check("R8 ls stays off", ls, 0);
    tick(1); check("R8 hs on", hs, 1);
    // R6 / R7 diode emulation with zc held high
    pwm = 2'b01; hsb = 1; zc = 1;
    tick(1); check("R6 hs low", hs, 0);
    tick(2); check("R6 ls wait", ls, 0);
    tick(1); check("R6 ls on", ls, 1);
    tick(3); check("R6 blank ignores zc", ls, 1);
    tick(1); check("R7 zc drops ls", ls, 0);
    tick(10); check("R7 stays low", ls, 0); check("R7 hs low", hs, 0);
    pwm = 2'b00;
    tick(4); check("R7 released by pwm", ls, 1);
    // R10 code 11 as mid
    pwm = 2'b11; zc = 0;
    tick(4); check("R10 pwm11 ls on", ls, 1);
    tick(10); check("R6 waits zc", ls, 1);
    zc = 1;
    tick(1); check("R10 pwm11 diode", ls, 0);
    // R3 enable mid/low, R9 return
    pwm = 2'b10;
    tick(5); check("R4 from diode", hs, 1);
    en = 2'b01;
    tick(1); check("R3 en mid hs", hs, 0); check("R3 en mid ls", ls, 0);
    tick(5); check("R3 en mid hold", hs, 0);
    en = 2'b11;
    tick(3); check("R10 en11 off", hs | ls, 0);
    en = 2'b00;
    tick(3); check("R3 en low off", hs | ls, 0);
    en = 2'b10;
    tick(1); check("R9 both low", hs | ls, 0);
    tick(3); check("R9 delay", hs, 0);
    tick(1); check("R9 hs on", hs, 1);
    // constrained random phase, checked against the model
    void'($urandom(32'h5eed));
    for (int i = 0; i < 40000; i++) begin
      if (i % 2000 == 0) begin
        dhs = CW'($urandom_range(0, 5));
        dls = CW'($urandom_range(0, 5));
        blk = CW'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 99) < 4) pwm = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) < 2) en = ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom_range(0, 3));
      if ($urandom_range(0, 399) < 2) sup = ($urandom_range(0, 3) != 0);
      hsb = ($urandom_range(0, 9) < 7) ? !hs : 1'($urandom_range(0, 1));
      lsb = ($urandom_range(0, 9) < 7) ? !ls : 1'($urandom_range(0, 1));
      zc  = ($urandom_range(0, 9) < 3);
      tick(1);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule